// File: doc/BRIEF.md
# Transition-Count Leakage Model for a Keyed Multiplier

This block models the switching activity of a register that captures the results of a multiplier with one fixed operand. A guessed value of that fixed operand (the key guess) is held on an input port. The same operands the real multiplier processed, in the same order, are streamed in. For each operand the block forms the full-width product with the key guess. It then reports how many bits differ between that product and the product before it, which is the number of bit flips the result register would see.

The output stream carries one value for each pair of consecutive operands. It can be used as a simulated leakage trace, or as the hypothesis column that feeds a correlation engine comparing guesses against measured power. One instance models one key guess.

A start pulse opens a new sequence, so the next accepted operand only seeds the history. Inputs use a valid/ready handshake. Outputs use valid/ready with backpressure, and they keep the order of the operands. A per-operand end marker is carried through to the output sample that operand produces.

Top module: `hd_leak_gen`

## Requirements
- R1: The product of each accepted operand is the full unsigned product `in_operand * key_hyp`, 2*OP_W bits wide, with no truncation.
- R2: Every output sample `out_dist` equals the number of 1 bits in the XOR of the products of two consecutively accepted operands, so its value lies between 0 and 2*OP_W.
- R3: A sequence of M accepted operands opened by a start pulse yields exactly M-1 output samples. The first operand after the start only stores its product.
- R4: If `start` is high in a cycle where an operand is accepted, that operand is the first of a new sequence. If `start` is high with no acceptance, the stored history is cleared and the next accepted operand is the first.
- R5: Without a start pulse the history continues: the first operand after an end marker is compared with the operand accepted before it.
- R6: While `key_hyp` is zero, `in_ready` is low and no operand is accepted. The stored history is left unchanged.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_dist` and `out_last` hold. No sample is lost, duplicated or reordered.
- R8: `out_last` equals the `in_last` value of the later operand of the pair that produced the sample.
- R9: With `out_ready` held high, a sample appears on the output 1 + log2(2*OP_W) clock edges after its later operand is accepted.
- R10: During reset and right after it, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| start | input | 1 | Opens a new sequence and clears the product history |
| key_hyp | input | OP_W | Key guess; must not be zero; held steady during a sequence |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand accepted when high together with in_valid |
| in_operand | input | OP_W | Known operand, in the target's processing order |
| in_last | input | 1 | End marker for the operand |
| out_valid | output | 1 | Leakage sample present |
| out_ready | input | 1 | Downstream takes the sample |
| out_dist | output | $clog2(2*OP_W+1) | Bit-flip count between consecutive products |
| out_last | output | 1 | End marker of the later operand |

## Verification
The bench builds the block with OP_W = 4, giving 8-bit products and a three-level count tree. In this size every nonzero key guess can be swept. Each guess gets several orderings that visit all sixteen operands, so every flip count from 0 to 8 occurs and the expected count is computed with plain arithmetic. Random input gaps and output stalls exercise ordering under backpressure. Directed segments cover a zero key guess, sequences that continue without a start pulse, and the exact pipeline latency.

// File: rtl/hdlg_pkg.sv
package hdlg_pkg;

  // Number of leaves in the balanced count tree for a vector of width w.
  function automatic int tree_leaves(input int w);
    return 1 << $clog2(w);
  endfunction

  // Register levels in the balanced count tree for a vector of width w.
  function automatic int tree_levels(input int w);
    return $clog2(w);
  endfunction

  // Bits needed to hold a count from 0 to w inclusive.
  function automatic int count_width(input int w);
    return $clog2(w + 1);
  endfunction

endpackage

// File: rtl/hdlg_diff_stage.sv
module hdlg_diff_stage #(
  parameter int OP_W   = 16,
  parameter int PROD_W = 2 * OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              acc,
  input  logic              start,
  input  logic [OP_W-1:0]   op,
  input  logic [OP_W-1:0]   key,
  input  logic              last,
  output logic [PROD_W-1:0] diff_q,
  output logic              dv_q,
  output logic              dlast_q
);

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] prev_q, prev_d;
  logic              have_prev_q, have_prev_d;
  logic [PROD_W-1:0] diff_d;
  logic              dv_d, dlast_d;

  // Full-width product of operand and key guess.
  assign prod = PROD_W'(op) * PROD_W'(key);

  // Next state: history of the previous product.
  always_comb begin
    prev_d      = prev_q;
    have_prev_d = have_prev_q;
    if (acc) begin
      prev_d      = prod;
      have_prev_d = 1'b1;
    end else if (start) begin
      prev_d      = '0;
      have_prev_d = 1'b0;
    end
  end

  // Next state: difference vector towards the count tree.
  always_comb begin
    diff_d  = diff_q;
    dv_d    = dv_q;
    dlast_d = dlast_q;
    if (en) begin
      dv_d = acc & have_prev_q & ~start;
      if (acc) begin
        diff_d  = prod ^ prev_q;
        dlast_d = last;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      diff_q      <= '0;
      dv_q        <= 1'b0;
      dlast_q     <= 1'b0;
    end else begin
      prev_q      <= prev_d;
      have_prev_q <= have_prev_d;
      diff_q      <= diff_d;
      dv_q        <= dv_d;
      dlast_q     <= dlast_d;
    end
  end

  // R3: the operand that opens a sequence sends nothing downstream.
  assert_first_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (start || !have_prev_q)) |=> !dv_q);

  // R4: a start pulse without an acceptance leaves an empty history.
  assert_start_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !acc) |=> (!have_prev_q && prev_q == '0));

  // R6: no operand is taken while the key guess is zero.
  assert_no_zero_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> (key != '0));

  // R6: a cycle without acceptance or start keeps the history.
  assert_history_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !start) |=> ($stable(prev_q) && $stable(have_prev_q)));

endmodule

// File: rtl/hdlg_pop_tree.sv
module hdlg_pop_tree
  import hdlg_pkg::*;
#(
  parameter int VEC_W  = 32,
  parameter int DIST_W = count_width(VEC_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [VEC_W-1:0]  in_vec,
  input  logic              in_vld,
  input  logic              in_last,
  output logic [DIST_W-1:0] out_cnt,
  output logic              out_vld,
  output logic              out_last
);

  localparam int LEVELS = tree_levels(VEC_W);
  localparam int N_LEAF = tree_leaves(VEC_W);
  localparam int N_NODE = N_LEAF - 1;

  logic [DIST_W-1:0] leaf   [N_LEAF];
  logic [DIST_W-1:0] sum_w  [N_NODE];
  logic [DIST_W-1:0] node_q [N_NODE];

  logic [LEVELS-1:0] vld_q, vld_d;
  logic [LEVELS-1:0] lst_q, lst_d;

  // Leaves: one bit each, padded with zeros up to a power of two.
  for (genvar i = 0; i < N_LEAF; i++) begin : g_leaf
    if (i < VEC_W) begin : g_bit
      assign leaf[i] = DIST_W'(in_vec[i]);
    end else begin : g_pad
      assign leaf[i] = '0;
    end
  end

  // Heap-ordered nodes: node k has children 2k+1 and 2k+2.
  for (genvar k = 0; k < N_NODE; k++) begin : g_node
    if (2 * k + 1 >= N_NODE) begin : g_from_leaf
      assign sum_w[k] = leaf[2*k+1-N_NODE] + leaf[2*k+2-N_NODE];
    end else begin : g_from_node
      assign sum_w[k] = node_q[2*k+1] + node_q[2*k+2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        node_q[k] <= '0;
      end else if (en) begin
        node_q[k] <= sum_w[k];
      end
    end
  end

  // Side-band shift register that travels with the tree levels.
  always_comb begin
    vld_d = vld_q;
    lst_d = lst_q;
    if (en) begin
      vld_d = {vld_q[LEVELS-2:0], in_vld};
      lst_d = {lst_q[LEVELS-2:0], in_last};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      lst_q <= '0;
    end else begin
      vld_q <= vld_d;
      lst_q <= lst_d;
    end
  end

  assign out_cnt  = node_q[0];
  assign out_vld  = vld_q[LEVELS-1];
  assign out_last = lst_q[LEVELS-1];

  // R2: a finished count never exceeds the vector width.
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_cnt <= DIST_W'(VEC_W)));

  // R7: a stalled tree does not move its output.
  assert_tree_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(out_cnt) && $stable(out_vld) && $stable(out_last)));

endmodule

// File: rtl/hd_leak_gen.sv
module hd_leak_gen
  import hdlg_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [OP_W-1:0]                 key_hyp,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic [OP_W-1:0]                 in_operand,
  input  logic                            in_last,
  output logic                            out_valid,
  input  logic                            out_ready,
  output logic [$clog2(2*OP_W+1)-1:0]     out_dist,
  output logic                            out_last
);

  localparam int PROD_W = 2 * OP_W;
  localparam int DIST_W = count_width(PROD_W);

  // Reset: asserted at once, released after two clock edges.
  logic [1:0] rst_sync_q, rst_sync_d;
  logic       rst_ni;

  assign rst_sync_d = {rst_sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= rst_sync_d;
    end
  end

  assign rst_ni = rst_sync_q[1];

  // Whole-pipeline advance: move unless a held sample blocks the exit.
  logic en;
  logic key_ok;
  logic acc;

  assign en       = ~out_valid | out_ready;
  assign key_ok   = |key_hyp;
  assign in_ready = en & key_ok & rst_ni;
  assign acc      = in_valid & in_ready;

  logic [PROD_W-1:0] diff_q;
  logic              dv_q;
  logic              dlast_q;

  hdlg_diff_stage #(
    .OP_W   (OP_W),
    .PROD_W (PROD_W)
  ) u_diff (
    .clk     (clk),
    .rst_n   (rst_ni),
    .en      (en),
    .acc     (acc),
    .start   (start),
    .op      (in_operand),
    .key     (key_hyp),
    .last    (in_last),
    .diff_q  (diff_q),
    .dv_q    (dv_q),
    .dlast_q (dlast_q)
  );

  hdlg_pop_tree #(
    .VEC_W  (PROD_W),
    .DIST_W (DIST_W)
  ) u_tree (
    .clk      (clk),
    .rst_n    (rst_ni),
    .en       (en),
    .in_vec   (diff_q),
    .in_vld   (dv_q),
    .in_last  (dlast_q),
    .out_cnt  (out_dist),
    .out_vld  (out_valid),
    .out_last (out_last)
  );

  // R7: a sample waiting on the consumer stays put.
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_dist) && $stable(out_last)));

  // R6: nothing enters while the exit is blocked.
  assert_no_entry_stalled_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && !out_ready) |-> !in_ready);

  // R10: the block leaves reset empty.
  assert_reset_empty_R10: assert property (@(posedge clk)
    !rst_ni |=> !out_valid);

endmodule

// File: tb/tb_hd_leak_gen.sv
`timescale 1ns/1ps
module tb_hd_leak_gen;

  localparam int OP_W   = 4;
  localparam int PROD_W = 2 * OP_W;
  localparam int DIST_W = $clog2(PROD_W + 1);
  localparam int LAT    = 1 + $clog2(PROD_W);

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [OP_W-1:0]   key_hyp;
  logic              in_valid;
  logic              in_ready;
  logic [OP_W-1:0]   in_operand;
  logic              in_last;
  logic              out_valid;
  logic              out_ready;
  logic [DIST_W-1:0] out_dist;
  logic              out_last;

  hd_leak_gen #(.OP_W(OP_W)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .key_hyp    (key_hyp),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_operand (in_operand),
    .in_last    (in_last),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_dist   (out_dist),
    .out_last   (out_last)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks;
  int errors;
  bit done;

  int exp_d[$];
  bit exp_l[$];
  int prev_p;
  bit have_prev;
  int outs_seen;
  int outs_expected;

  function automatic int popc(input int v);
    int c = 0;
    for (int b = 0; b < 32; b++) c += (v >> b) & 1;
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle, entered and left just after a falling edge.
  task automatic tick(input bit iv, input bit [OP_W-1:0] op, input bit il,
                      input bit st, input bit ordy, output bit took);
    int p;
    in_valid   = iv;
    in_operand = op;
    in_last    = il;
    start      = st;
    out_ready  = ordy;
    #1;
    if (out_valid && out_ready) begin
      outs_seen++;
      if (exp_d.size() == 0) begin
        check(1'b0, "R3 extra sample", int'(out_dist), -1);
      end else begin
        // R1 R2: flip count of consecutive products; R7 order kept
        check(int'(out_dist) == exp_d[0], "R2 distance", int'(out_dist), exp_d[0]);
        // R8: end marker travels with its sample
        check(out_last == exp_l[0], "R8 last flag", int'(out_last), int'(exp_l[0]));
        void'(exp_d.pop_front());
        void'(exp_l.pop_front());
      end
    end
    took = iv && in_ready;
    if (took) begin
      p = int'(op) * int'(key_hyp);
      if (!st && have_prev) begin
        exp_d.push_back(popc(p ^ prev_p));
        exp_l.push_back(il);
        outs_expected++;
      end
      prev_p    = p;
      have_prev = 1'b1;
    end else if (st) begin
      prev_p    = 0;
      have_prev = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  // Sends a full permutation of operands for the current key guess.
  task automatic run_seq(input int base, input int step, input bit use_start, input bit bp);
    int idx = 0;
    bit took;
    while (idx < (1 << OP_W)) begin
      tick(($urandom % 4) != 0, OP_W'(base + idx * step), idx == (1 << OP_W) - 1,
           use_start && idx == 0, bp ? (($urandom % 3) != 0) : 1'b1, took);
      if (took) idx++;
    end
  endtask

  task automatic drain();
    bit took;
    for (int i = 0; i < 40; i++) tick(1'b0, '0, 1'b0, 1'b0, 1'b1, took);
  endtask

  initial begin
    int first_seen;
    bit took;
    checks = 0; errors = 0; done = 0;
    prev_p = 0; have_prev = 0; outs_seen = 0; outs_expected = 0;
    rst_n = 1'b0; start = 1'b0; key_hyp = 4'd3;
    in_valid = 1'b0; in_operand = '0; in_last = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R10 valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R10 valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R10 ready after reset", int'(in_ready), 1);

    // R9: latency with a free output; 3*1 vs 3*2 gives 2 flips
    tick(1'b1, 4'd1, 1'b0, 1'b1, 1'b1, took);
    tick(1'b1, 4'd2, 1'b1, 1'b0, 1'b1, took);
    first_seen = 0;
    for (int j = 1; j <= 10; j++) begin
      in_valid = 1'b0;
      #1;
      if (out_valid && first_seen == 0) first_seen = j;
      tick(1'b0, '0, 1'b0, 1'b0, 1'b1, took);
    end
    check(first_seen == LAT, "R9 latency", first_seen, LAT);

    // R6: zero key guess blocks input and leaves history alone
    key_hyp = '0;
    for (int j = 0; j < 5; j++) begin
      in_valid = 1'b1;
      #1;
      check(in_ready == 1'b0, "R6 ready with zero key", int'(in_ready), 0);
      tick(1'b1, 4'd9, 1'b0, 1'b0, 1'b1, took);
      check(took == 1'b0, "R6 accepted with zero key", int'(took), 0);
    end
    check(out_valid == 1'b0, "R6 output with zero key", int'(out_valid), 0);
    key_hyp = 4'd3;
    // R5: continues from operand 2 of the latency test without a start
    tick(1'b1, 4'd7, 1'b0, 1'b0, 1'b1, took);
    drain();

    // R1 R2 R3 R4 R7 R8: every nonzero key, several orderings, stalls
    for (int k = 1; k < (1 << OP_W); k++) begin
      key_hyp = OP_W'(k);
      run_seq(k, 1, 1'b1, 1'b0);
      run_seq(3 * k, 5, 1'b1, 1'b1);
      run_seq(k + 7, 11, 1'b1, 1'b1);
      // R5: no start, history carries over the end marker
      run_seq(2 * k, 13, 1'b0, 1'b1);
      drain();
    end

    // R4: start with no acceptance, then a fresh pair
    key_hyp = 4'd9;
    tick(1'b0, '0, 1'b0, 1'b1, 1'b1, took);
    tick(1'b1, 4'd15, 1'b0, 1'b0, 1'b1, took);
    tick(1'b1, 4'd0, 1'b1, 1'b0, 1'b1, took);
    drain();

    check(exp_d.size() == 0, "R3 pending samples", exp_d.size(), 0);
    check(outs_seen == outs_expected, "R3 sample count", outs_seen, outs_expected);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule